// File: doc/BRIEF.md
# SVGA Extended Control Register File

This block is the byte-wide indexed register file that sits beside a VGA-compatible display controller. It adds vendor extension registers to the sequencer, CRTC and graphics-controller index/data pairs. It also provides a second sequencer port pair that aliases the standard one. A host drives a 3-bit port select, read and write strobes and a data byte. The block returns read data and a set of decoded control fields.

The register file has an old and a new register mode. It starts in old mode. Reading the chip-identification register switches it to new mode, and it stays there until reset. The mode decides how the memory bank register is decoded.

The upper bits of the display start address and of the row offset come from extension registers. The lower bits come from the standard CRTC registers, and each source updates only its own bits. Enable flags for the linear aperture and the memory-mapped I/O window are taken from their extension registers.

Top module: `svga_ext_regs`

## Requirements
- R1: `ioAddr` selects a port: 0 sequencer index, 1 sequencer data, 2 CRTC index, 3 CRTC data, 4 graphics index, 5 graphics data, 6 alternate sequencer data, 7 alternate sequencer index. Each index is an 8-bit register, and reading an index port returns its value. Data accesses use the most recently written index. A write takes effect on the clock edge that samples `wrEn`. `rdData` is combinational while `rdEn` is high and is 0 while `rdEn` is low.
- R2: After reset the following are all 0: `newMode`, `linearEn`, `mmioEn`, `startAddr`, `rowOffset`, `bankW` and `bankR`. The read-only sequencer index 0x09 returns the revision 0x05.
- R3: Reading sequencer index 0x0B returns 0xD3. `newMode` is then 1 from the next clock edge and stays 1 until reset.
- R4: Sequencer index 0x0C stores the written byte and reads it back with bit 4 forced to 0.
- R5: The effect of writing byte d to sequencer index 0x0E depends on the mode.
  - In old mode, `bankW` becomes d & 0x0E.
  - In new mode, `bankW` becomes (d & 0x1F) ^ 0x02.
  - In both modes, `bankR` takes the same value unless bit 0 of graphics index 0x0F is 1, in which case `bankR` is unchanged.
  - Reading 0x0E returns the last byte written to it in the current mode.
- R6: `startAddr[15:8]` is CRTC index 0x0C, `startAddr[7:0]` is CRTC index 0x0D, and `rowOffset[7:0]` is CRTC index 0x13.
- R7: Writing CRTC index 0x1E stores the byte and copies data bit 5 to `startAddr[16]`. No other `startAddr` bit changes.
- R8: Writing CRTC index 0x27 copies data bits 1:0 to `startAddr[18:17]` and leaves `startAddr[16:0]` unchanged. Reading 0x27 returns `startAddr[18:17]` in bits 1:0, with the other bits 0.
- R9: Writing CRTC index 0x29 stores the byte and copies data bit 4 to `rowOffset[8]`. `rowOffset[7:0]` is unchanged.
- R10: `linearEn` is bit 5 of CRTC index 0x21, and `mmioEn` is bit 0 of CRTC index 0x39. CRTC indices 0x1F, 0x21, 0x38, 0x39 and 0x50 read back the stored byte.
- R11: Port 6 reads and writes the same sequencer register as port 1. Port 7 reads and writes the same sequencer index as port 0.
- R12: Graphics indices 0x00–0x08, 0x0E, 0x0F and 0x2F store and read back their bytes. Reading any other graphics index returns 0xFF.
- R13: CRTC indices below 0x50 without an extension meaning read back the stored byte. CRTC indices above 0x50 read 0x00 and ignore writes.
- R14: Sequencer indices 0x00–0x07 read back the stored byte. Sequencer indices that are neither standard nor extension registers read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 3 | Port select (see R1) |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte for the selected port |
| startAddr | output | 19 | Display start address |
| rowOffset | output | 9 | Display row offset |
| bankW | output | 5 | Write bank number |
| bankR | output | 5 | Read bank number |
| newMode | output | 1 | New register mode flag |
| linearEn | output | 1 | Linear aperture enable |
| mmioEn | output | 1 | Memory-mapped I/O enable |

## Verification
Read data depends only on the current index and the stored state, so it is valid in the same cycle as `rdEn`. The bench drives each read at a falling edge and compares `rdData` one nanosecond later. Writes, index updates and the mode switch triggered by a read all change on the next rising edge. The bench therefore checks `startAddr`, `rowOffset`, the bank numbers and the flags at the falling edge that follows that rising edge, and updates its own model at the same point.

// File: rtl/svga_ext_pkg.sv
package svga_ext_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned START_W  = 19;
  localparam int unsigned ROWOFF_W = 9;
  localparam int unsigned BANK_W   = 5;

  typedef enum logic [2:0] {
    PORT_SEQ_IDX  = 3'd0,
    PORT_SEQ_DAT  = 3'd1,
    PORT_CRTC_IDX = 3'd2,
    PORT_CRTC_DAT = 3'd3,
    PORT_GC_IDX   = 3'd4,
    PORT_GC_DAT   = 3'd5,
    PORT_ALT_DAT  = 3'd6,
    PORT_ALT_IDX  = 3'd7
  } ioPort_e;

  // sequencer extension indices
  localparam logic [7:0] IDX_SEQ_REV  = 8'h09;
  localparam logic [7:0] IDX_SEQ_ID   = 8'h0B;
  localparam logic [7:0] IDX_SEQ_PWR  = 8'h0C;
  localparam logic [7:0] IDX_SEQ_BANK = 8'h0E;
  // CRTC indices
  localparam logic [7:0] IDX_CR_START_MID = 8'h0C;
  localparam logic [7:0] IDX_CR_START_LO  = 8'h0D;
  localparam logic [7:0] IDX_CR_ROWOFF    = 8'h13;
  localparam logic [7:0] IDX_CR_MODTEST   = 8'h1E;
  localparam logic [7:0] IDX_CR_SWPROG    = 8'h1F;
  localparam logic [7:0] IDX_CR_LINEAR    = 8'h21;
  localparam logic [7:0] IDX_CR_START_HI  = 8'h27;
  localparam logic [7:0] IDX_CR_ROWOFF_HI = 8'h29;
  localparam logic [7:0] IDX_CR_PIXDEPTH  = 8'h38;
  localparam logic [7:0] IDX_CR_MMIO      = 8'h39;
  localparam logic [7:0] IDX_CR_SCRATCH   = 8'h50;
  // graphics extension indices
  localparam logic [7:0] IDX_GC_PAGE    = 8'h0E;
  localparam logic [7:0] IDX_GC_BANKCFG = 8'h0F;
  localparam logic [7:0] IDX_GC_MISC    = 8'h2F;

  typedef struct packed {
    logic              seqWr;
    logic              crtcWr;
    logic              gcWr;
    logic              idRead;
    logic [DATA_W-1:0] seqIdx;
    logic [DATA_W-1:0] crtcIdx;
    logic [DATA_W-1:0] gcIdx;
    logic [DATA_W-1:0] wrByte;
  } regStrobes_t;
endpackage

// File: rtl/svga_ext_ctrl.sv
module svga_ext_ctrl
  import svga_ext_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ioAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] seqData,
  input  logic [DATA_W-1:0] crtcData,
  input  logic [DATA_W-1:0] gcData,
  output regStrobes_t       strb,
  output logic [DATA_W-1:0] rdData
);
  ioPort_e port;
  logic [DATA_W-1:0] seqIdx, crtcIdx, gcIdx;
  logic seqDatPort;

  assign port       = ioPort_e'(ioAddr);
  assign seqDatPort = (port == PORT_SEQ_DAT) || (port == PORT_ALT_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqIdx  <= '0;
      crtcIdx <= '0;
      gcIdx   <= '0;
    end else if (wrEn) begin
      case (port)
        PORT_SEQ_IDX, PORT_ALT_IDX: seqIdx  <= wrData;
        PORT_CRTC_IDX:              crtcIdx <= wrData;
        PORT_GC_IDX:                gcIdx   <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.seqWr   = wrEn && seqDatPort;
    strb.crtcWr  = wrEn && (port == PORT_CRTC_DAT);
    strb.gcWr    = wrEn && (port == PORT_GC_DAT);
    strb.idRead  = rdEn && seqDatPort && (seqIdx == IDX_SEQ_ID);
    strb.seqIdx  = seqIdx;
    strb.crtcIdx = crtcIdx;
    strb.gcIdx   = gcIdx;
    strb.wrByte  = wrData;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (port)
        PORT_SEQ_IDX, PORT_ALT_IDX: rdData = seqIdx;
        PORT_SEQ_DAT, PORT_ALT_DAT: rdData = seqData;
        PORT_CRTC_IDX:              rdData = crtcIdx;
        PORT_CRTC_DAT:              rdData = crtcData;
        PORT_GC_IDX:                rdData = gcIdx;
        PORT_GC_DAT:                rdData = gcData;
        default:                    rdData = '0;
      endcase
    end
  end

  // R11: alternate index port lands in the sequencer index
  assert_alias_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && port == PORT_ALT_IDX) |=> (strb.seqIdx == $past(wrData)));

  // R1: index written on one edge is used from the next
  assert_crtc_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && port == PORT_CRTC_IDX) |=> (strb.crtcIdx == $past(wrData)));
endmodule

// File: rtl/svga_ext_dp.sv
module svga_ext_dp
  import svga_ext_pkg::*;
#(
  parameter int unsigned SEQ_STD_CNT  = 8,
  parameter int unsigned CRTC_STD_CNT = 80,
  parameter int unsigned GC_STD_CNT   = 9,
  parameter logic [7:0]  CHIP_ID      = 8'hD3,
  parameter logic [7:0]  REV_ID       = 8'h05
) (
  input  logic                clk,
  input  logic                rst_n,
  input  regStrobes_t         strb,
  output logic [DATA_W-1:0]   seqData,
  output logic [DATA_W-1:0]   crtcData,
  output logic [DATA_W-1:0]   gcData,
  output logic [START_W-1:0]  startAddr,
  output logic [ROWOFF_W-1:0] rowOffset,
  output logic [BANK_W-1:0]   bankW,
  output logic [BANK_W-1:0]   bankR,
  output logic                newMode,
  output logic                linearEn,
  output logic                mmioEn
);
  localparam int unsigned SEQ_IW  = $clog2(SEQ_STD_CNT);
  localparam int unsigned CRTC_IW = $clog2(CRTC_STD_CNT);
  localparam int unsigned GC_IW   = $clog2(GC_STD_CNT);
  localparam logic [7:0] SEQ_LIM  = 8'(SEQ_STD_CNT);
  localparam logic [7:0] CRTC_LIM = 8'(CRTC_STD_CNT);
  localparam logic [7:0] GC_LIM   = 8'(GC_STD_CNT);
  localparam logic [CRTC_IW-1:0] POS_START_MID = CRTC_IW'(IDX_CR_START_MID);
  localparam logic [CRTC_IW-1:0] POS_START_LO  = CRTC_IW'(IDX_CR_START_LO);
  localparam logic [CRTC_IW-1:0] POS_ROWOFF    = CRTC_IW'(IDX_CR_ROWOFF);
  localparam logic [BANK_W-1:0]  BANK_FLIP     = BANK_W'(2);
  localparam logic [BANK_W-1:0]  OLD_MASK      = BANK_W'(14);

  logic [SEQ_STD_CNT-1:0][DATA_W-1:0]  seqStd;
  logic [CRTC_STD_CNT-1:0][DATA_W-1:0] crtcStd;
  logic [GC_STD_CNT-1:0][DATA_W-1:0]   gcStd;

  logic [DATA_W-1:0] pwrReg, bankOld, bankNew;
  logic [DATA_W-1:0] modTest, swProg, linearReg, rowOffHi, pixDepth, mmioReg, scratch;
  logic [DATA_W-1:0] gcPage, gcBankCfg, gcMisc;
  logic [1:0]        startHi;
  logic [BANK_W-1:0] bankDecoded;

  logic seqBankWr, crtcExtHit;
  assign seqBankWr = strb.seqWr && (strb.seqIdx == IDX_SEQ_BANK);

  // standard register arrays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqStd  <= '0;
      crtcStd <= '0;
      gcStd   <= '0;
    end else begin
      if (strb.seqWr && strb.seqIdx < SEQ_LIM)
        seqStd[strb.seqIdx[SEQ_IW-1:0]] <= strb.wrByte;
      if (strb.crtcWr && strb.crtcIdx < CRTC_LIM)
        crtcStd[strb.crtcIdx[CRTC_IW-1:0]] <= strb.wrByte;
      if (strb.gcWr && strb.gcIdx < GC_LIM)
        gcStd[strb.gcIdx[GC_IW-1:0]] <= strb.wrByte;
    end
  end

  // sequencer extensions, mode flag and bank decode
  always_comb begin
    if (newMode) bankDecoded = strb.wrByte[BANK_W-1:0] ^ BANK_FLIP;
    else         bankDecoded = strb.wrByte[BANK_W-1:0] & OLD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      newMode <= 1'b0;
      pwrReg  <= '0;
      bankOld <= '0;
      bankNew <= '0;
      bankW   <= '0;
      bankR   <= '0;
    end else begin
      if (strb.idRead) newMode <= 1'b1;
      if (strb.seqWr && strb.seqIdx == IDX_SEQ_PWR) pwrReg <= strb.wrByte;
      if (seqBankWr) begin
        if (newMode) bankNew <= strb.wrByte;
        else         bankOld <= strb.wrByte;
        bankW <= bankDecoded;
        if (!gcBankCfg[0]) bankR <= bankDecoded;
      end
    end
  end

  // CRTC extensions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modTest   <= '0;
      swProg    <= '0;
      linearReg <= '0;
      rowOffHi  <= '0;
      pixDepth  <= '0;
      mmioReg   <= '0;
      scratch   <= '0;
      startHi   <= '0;
    end else if (strb.crtcWr) begin
      case (strb.crtcIdx)
        IDX_CR_MODTEST:   modTest   <= strb.wrByte;
        IDX_CR_SWPROG:    swProg    <= strb.wrByte;
        IDX_CR_LINEAR:    linearReg <= strb.wrByte;
        IDX_CR_START_HI:  startHi   <= strb.wrByte[1:0];
        IDX_CR_ROWOFF_HI: rowOffHi  <= strb.wrByte;
        IDX_CR_PIXDEPTH:  pixDepth  <= strb.wrByte;
        IDX_CR_MMIO:      mmioReg   <= strb.wrByte;
        IDX_CR_SCRATCH:   scratch   <= strb.wrByte;
        default: ;
      endcase
    end
  end

  // graphics extensions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcPage    <= '0;
      gcBankCfg <= '0;
      gcMisc    <= '0;
    end else if (strb.gcWr) begin
      case (strb.gcIdx)
        IDX_GC_PAGE:    gcPage    <= strb.wrByte;
        IDX_GC_BANKCFG: gcBankCfg <= strb.wrByte;
        IDX_GC_MISC:    gcMisc    <= strb.wrByte;
        default: ;
      endcase
    end
  end

  // decoded fields: each source owns its own bits
  assign startAddr = {startHi, modTest[5], crtcStd[POS_START_MID], crtcStd[POS_START_LO]};
  assign rowOffset = {rowOffHi[4], crtcStd[POS_ROWOFF]};
  assign linearEn  = linearReg[5];
  assign mmioEn    = mmioReg[0];

  // read multiplexers
  always_comb begin
    case (strb.seqIdx)
      IDX_SEQ_REV:  seqData = REV_ID;
      IDX_SEQ_ID:   seqData = CHIP_ID;
      IDX_SEQ_PWR:  seqData = pwrReg & 8'hEF;
      IDX_SEQ_BANK: seqData = newMode ? bankNew : bankOld;
      default:      seqData = (strb.seqIdx < SEQ_LIM) ? seqStd[strb.seqIdx[SEQ_IW-1:0]] : '0;
    endcase
  end

  always_comb begin
    crtcExtHit = 1'b1;
    case (strb.crtcIdx)
      IDX_CR_MODTEST:   crtcData = modTest;
      IDX_CR_SWPROG:    crtcData = swProg;
      IDX_CR_LINEAR:    crtcData = linearReg;
      IDX_CR_START_HI:  crtcData = {6'b0, startHi};
      IDX_CR_ROWOFF_HI: crtcData = rowOffHi;
      IDX_CR_PIXDEPTH:  crtcData = pixDepth;
      IDX_CR_MMIO:      crtcData = mmioReg;
      IDX_CR_SCRATCH:   crtcData = scratch;
      default: begin
        crtcExtHit = 1'b0;
        crtcData   = (strb.crtcIdx < CRTC_LIM) ? crtcStd[strb.crtcIdx[CRTC_IW-1:0]] : '0;
      end
    endcase
  end

  always_comb begin
    case (strb.gcIdx)
      IDX_GC_PAGE:    gcData = gcPage;
      IDX_GC_BANKCFG: gcData = gcBankCfg;
      IDX_GC_MISC:    gcData = gcMisc;
      default:        gcData = (strb.gcIdx < GC_LIM) ? gcStd[strb.gcIdx[GC_IW-1:0]] : 8'hFF;
    endcase
  end

  // R3: identification read enters new mode, which never leaves
  assert_id_sets_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.idRead |=> newMode);
  assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(newMode));

  // R5: read bank frozen while the graphics lock bit is set
  assert_bank_read_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gcBankCfg[0] |=> $stable(bankR));

  // R8: high start bits from index 0x27, low bits untouched
  assert_start_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.crtcWr && strb.crtcIdx == IDX_CR_START_HI) |=>
      (startAddr[18:17] == $past(strb.wrByte[1:0])) && $stable(startAddr[16:0]));

  // R7: mod-test write only moves bit 16 of the start address
  assert_start_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.crtcWr && strb.crtcIdx == IDX_CR_MODTEST) |=>
      $stable(startAddr[15:0]) && $stable(startAddr[18:17]));

  // R9: row offset high bit without disturbing the low byte
  assert_rowoff_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.crtcWr && strb.crtcIdx == IDX_CR_ROWOFF_HI) |=>
      (rowOffset[8] == $past(strb.wrByte[4])) && $stable(rowOffset[7:0]));

  // R10: mmio enable only moves on a write to its own index
  assert_mmio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.crtcWr && strb.crtcIdx == IDX_CR_MMIO) |=> $stable(mmioEn));

  // R13: extension hits never come from the standard array path
  assert_ext_decode_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (crtcExtHit && strb.crtcIdx == IDX_CR_START_HI) |-> (crtcData[7:2] == 6'b0));
endmodule

// File: rtl/svga_ext_regs.sv
module svga_ext_regs
  import svga_ext_pkg::*;
#(
  parameter int unsigned SEQ_STD_CNT  = 8,
  parameter int unsigned CRTC_STD_CNT = 80,
  parameter int unsigned GC_STD_CNT   = 9,
  parameter logic [7:0]  CHIP_ID      = 8'hD3,
  parameter logic [7:0]  REV_ID       = 8'h05
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          ioAddr,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [START_W-1:0]  startAddr,
  output logic [ROWOFF_W-1:0] rowOffset,
  output logic [BANK_W-1:0]   bankW,
  output logic [BANK_W-1:0]   bankR,
  output logic                newMode,
  output logic                linearEn,
  output logic                mmioEn
);
  regStrobes_t strb;
  logic [DATA_W-1:0] seqData, crtcData, gcData;

  svga_ext_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ioAddr   (ioAddr),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .seqData  (seqData),
    .crtcData (crtcData),
    .gcData   (gcData),
    .strb     (strb),
    .rdData   (rdData)
  );

  svga_ext_dp #(
    .SEQ_STD_CNT  (SEQ_STD_CNT),
    .CRTC_STD_CNT (CRTC_STD_CNT),
    .GC_STD_CNT   (GC_STD_CNT),
    .CHIP_ID      (CHIP_ID),
    .REV_ID       (REV_ID)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .seqData   (seqData),
    .crtcData  (crtcData),
    .gcData    (gcData),
    .startAddr (startAddr),
    .rowOffset (rowOffset),
    .bankW     (bankW),
    .bankR     (bankR),
    .newMode   (newMode),
    .linearEn  (linearEn),
    .mmioEn    (mmioEn)
  );
endmodule

// File: tb/svga_ext_regs_bench.sv
module svga_ext_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ioAddr;
  logic        rdEn, wrEn;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic [18:0] startAddr;
  logic [8:0]  rowOffset;
  logic [4:0]  bankW, bankR;
  logic        newMode, linearEn, mmioEn;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0] mSeq [256];
  logic [7:0] mCrtc[256];
  logic [7:0] mGc  [256];
  logic [7:0] mSeqIdx, mCrtcIdx, mGcIdx, mBankOld, mBankNew;
  logic [1:0] mStartHi;
  logic [4:0] mBankW, mBankR;
  logic       mNew;

  always #(CLK_PERIOD/2) clk = ~clk;

  svga_ext_regs u_svga_ext_regs (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .startAddr(startAddr), .rowOffset(rowOffset),
    .bankW(bankW), .bankR(bankR), .newMode(newMode), .linearEn(linearEn), .mmioEn(mmioEn)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] expSeq(input logic [7:0] idx);
    if (idx == 8'h09) return 8'h05;
    if (idx == 8'h0B) return 8'hD3;
    if (idx == 8'h0C) return mSeq[idx] & 8'hEF;
    if (idx == 8'h0E) return mNew ? mBankNew : mBankOld;
    if (idx < 8'h08)  return mSeq[idx];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expCrtc(input logic [7:0] idx);
    if (idx == 8'h27) return {6'b0, mStartHi};
    if (idx <= 8'h50) return mCrtc[idx];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expGc(input logic [7:0] idx);
    if (idx < 8'h09 || idx == 8'h0E || idx == 8'h0F || idx == 8'h2F) return mGc[idx];
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] p);
    case (p)
      3'd0, 3'd7: return mSeqIdx;
      3'd1, 3'd6: return expSeq(mSeqIdx);
      3'd2:       return mCrtcIdx;
      3'd3:       return expCrtc(mCrtcIdx);
      3'd4:       return mGcIdx;
      default:    return expGc(mGcIdx);
    endcase
  endfunction

  task automatic modelWrite(input logic [2:0] p, input logic [7:0] d);
    logic [4:0] dec;
    case (p)
      3'd0, 3'd7: mSeqIdx = d;
      3'd2:       mCrtcIdx = d;
      3'd4:       mGcIdx = d;
      3'd1, 3'd6: begin
        if (mSeqIdx < 8'h08 || mSeqIdx == 8'h0C) mSeq[mSeqIdx] = d;
        if (mSeqIdx == 8'h0E) begin
          if (mNew) begin mBankNew = d; dec = (d[4:0] & 5'h1F) ^ 5'h02; end
          else      begin mBankOld = d; dec = d[4:0] & 5'h0E; end
          mBankW = dec;
          if (!mGc[8'h0F][0]) mBankR = dec;
        end
      end
      3'd3: begin
        if (mCrtcIdx == 8'h27) mStartHi = d[1:0];
        else if (mCrtcIdx <= 8'h50) mCrtc[mCrtcIdx] = d;
      end
      default: if (mGcIdx < 8'h09 || mGcIdx == 8'h0E || mGcIdx == 8'h0F || mGcIdx == 8'h2F) mGc[mGcIdx] = d;
    endcase
  endtask

  task automatic modelReset();
    for (int i = 0; i < 256; i++) begin mSeq[i] = 0; mCrtc[i] = 0; mGc[i] = 0; end
    mSeqIdx = 0; mCrtcIdx = 0; mGcIdx = 0; mBankOld = 0; mBankNew = 0;
    mStartHi = 0; mBankW = 0; mBankR = 0; mNew = 0;
  endtask

  task automatic checkOuts();
    check("R6", "startAddr", startAddr, {mStartHi, mCrtc[8'h1E][5], mCrtc[8'h0C], mCrtc[8'h0D]});
    check("R9", "rowOffset", rowOffset, {mCrtc[8'h29][4], mCrtc[8'h13]});
    check("R10", "linearEn", linearEn, mCrtc[8'h21][5]);
    check("R10", "mmioEn", mmioEn, mCrtc[8'h39][0]);
    check("R5", "bankW", bankW, mBankW);
    check("R5", "bankR", bankR, mBankR);
    check("R3", "newMode", newMode, mNew);
  endtask

  // tasks start and end at a falling edge
  task automatic doWrite(input logic [2:0] p, input logic [7:0] d);
    ioAddr = p; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    modelWrite(p, d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] p, input string tag);
    ioAddr = p; rdEn = 1'b1;
    #1;
    check(tag, "rdData", rdData, expRead(p));
    @(posedge clk);
    if ((p == 3'd1 || p == 3'd6) && mSeqIdx == 8'h0B) mNew = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0; rdEn = 1'b0; wrEn = 1'b0; ioAddr = 0; wrData = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic randomPhase(input int ops, input bit allowId);
    logic [7:0] picks [16] = '{8'h0B, 8'h0C, 8'h0E, 8'h09, 8'h1E, 8'h27, 8'h29, 8'h21,
                              8'h39, 8'h13, 8'h0D, 8'h0F, 8'h2F, 8'h50, 8'h03, 8'h60};
    for (int n = 0; n < ops; n++) begin
      logic [2:0] p;
      logic [7:0] d;
      p = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) begin
        if ((p == 3'd1 || p == 3'd6) && mSeqIdx == 8'h0B && !allowId) doWrite(p, 8'($urandom));
        else doRead(p, "R1");
      end else begin
        if (p == 3'd0 || p == 3'd7 || p == 3'd2 || p == 3'd4)
          d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : picks[$urandom_range(0, 15)];
        else
          d = 8'($urandom);
        doWrite(p, d);
      end
      checkOuts();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    doReset();
    // R2: reset state and revision
    checkOuts();
    doWrite(3'd0, 8'h09); doRead(3'd1, "R2");
    // R14: unassigned sequencer index ignores writes
    doWrite(3'd0, 8'h0A); doWrite(3'd1, 8'h77); doRead(3'd1, "R14");
    doWrite(3'd0, 8'h05); doWrite(3'd1, 8'h3C); doRead(3'd1, "R14");
    // R4: bit 4 masked
    doWrite(3'd0, 8'h0C); doWrite(3'd1, 8'hFF); doRead(3'd1, "R4");
    // R5 old mode decode
    doWrite(3'd0, 8'h0E); doWrite(3'd1, 8'hFF);
    check("R5", "old bankW", bankW, 5'h0E); doRead(3'd1, "R5");
    // R3: chip id and mode switch
    doWrite(3'd0, 8'h0B); doRead(3'd1, "R3");
    check("R3", "newMode", newMode, 1'b1);
    // R5 new mode decode, then locked read bank
    doWrite(3'd0, 8'h0E); doWrite(3'd1, 8'h13);
    check("R5", "new bankW", bankW, 5'h11); check("R5", "new bankR", bankR, 5'h11);
    doWrite(3'd4, 8'h0F); doWrite(3'd5, 8'h01);
    doWrite(3'd0, 8'h0E); doWrite(3'd1, 8'h05);
    check("R5", "locked bankW", bankW, 5'h07); check("R5", "locked bankR", bankR, 5'h11);
    // R6 R7 R8: start address assembly
    doWrite(3'd2, 8'h0C); doWrite(3'd3, 8'hAB);
    doWrite(3'd2, 8'h0D); doWrite(3'd3, 8'hCD);
    doWrite(3'd2, 8'h1E); doWrite(3'd3, 8'h20);
    check("R7", "startAddr", startAddr, 19'h1ABCD);
    doWrite(3'd2, 8'h27); doWrite(3'd3, 8'hFF);
    check("R8", "startAddr", startAddr, 19'h7ABCD); doRead(3'd3, "R8");
    doWrite(3'd2, 8'h1E); doWrite(3'd3, 8'hDF);
    check("R7", "startAddr clear16", startAddr, 19'h6ABCD);
    // R9: row offset
    doWrite(3'd2, 8'h13); doWrite(3'd3, 8'h55);
    doWrite(3'd2, 8'h29); doWrite(3'd3, 8'h10);
    check("R9", "rowOffset", rowOffset, 9'h155); doRead(3'd3, "R9");
    // R10: enables
    doWrite(3'd2, 8'h21); doWrite(3'd3, 8'h20); check("R10", "linearEn", linearEn, 1'b1);
    doWrite(3'd2, 8'h39); doWrite(3'd3, 8'h01); check("R10", "mmioEn", mmioEn, 1'b1);
    doRead(3'd3, "R10");
    // R13: beyond the standard range
    doWrite(3'd2, 8'h60); doWrite(3'd3, 8'h99); doRead(3'd3, "R13");
    doWrite(3'd2, 8'h40); doWrite(3'd3, 8'h99); doRead(3'd3, "R13");
    // R12: graphics extensions and unimplemented
    doWrite(3'd4, 8'h20); doWrite(3'd5, 8'h12); doRead(3'd5, "R12");
    doWrite(3'd4, 8'h2F); doWrite(3'd5, 8'h04); doRead(3'd5, "R12");
    // R11: alternate sequencer ports
    doWrite(3'd7, 8'h0C); doRead(3'd0, "R11");
    doWrite(3'd6, 8'h3C); doRead(3'd1, "R11"); doRead(3'd7, "R11");
    checkOuts();
    // random mix, old mode kept, then free
    doReset();
    randomPhase(1500, 1'b0);
    doReset();
    randomPhase(1500, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule